// File: doc/BRIEF.md
# Convolution-History Right-Hand-Side Engine

This block builds the right-hand side of one step of a time-marching boundary element recurrence. It keeps a bank of L coefficient matrices G1..GL and a ring of the L most recent solution vectors, each of N signed integer elements. For step n it forms, element by element, the self-field vector minus the sum over l of Gl times B(n-l). It then streams that vector to a downstream solver. The solver later returns B(n-1), or in a later step B(n), through a solution stream. Each accepted solution becomes the newest history entry, and the oldest entry is dropped.

Four multiply-accumulate lanes work at the same time. Lane k takes the terms l = k+1, k+5, k+9 and so on, in turn. Every term except G1 times the newest solution uses history that is already stored, so those terms are computed while the solver is still busy. Only the G1 term waits for the solution. The four lane partial vectors and the self-field element are combined, then saturated to 32 bits, as each output element is sent. A host fills the coefficients, the initial history and the self-field vector through a single-word load port while the block is idle.

Top module: `conv_rhs_engine`

## Requirements
- R1: Output element i equals sat32(S[i] − Σ_{l=1..L} Σ_j G_l[i][j]·H(l−1)[j]), computed exactly in integer arithmetic. H(a) is the history vector of age a, with age 0 the newest. Elements are sent in the order i = 0..N−1.
- R2: A result above 2147483647 is sent as 0x7FFFFFFF, and a result below −2147483648 is sent as 0x80000000.
- R3: The load port takes one word per cycle with ld_en high. ld_sel 0 writes G_(ld_term+1)[ld_row][ld_col], ld_sel 1 writes history age ld_term element ld_col, and ld_sel 2 writes self-field element ld_col. A load has effect only while the block is idle. A load while a step is running is ignored.
- R4: A start pulse while idle begins a step. All terms that do not need a new solution are accumulated in N·N·ceil(L/4) cycles. When a new solution is needed, sol_ready rises exactly that many cycles after the start edge (50 with the defaults).
- R5: While waiting for a solution, the block holds sol_ready high and rhs_valid low for as long as the solver takes. It accepts N elements, in order, on cycles where both sol_valid and sol_ready are high.
- R6: After the last solution element is accepted, rhs_valid rises exactly N·N cycles later (25 with the defaults).
- R7: An accepted solution becomes history age 0, and every older entry moves up one age. The entry of age L−1 is discarded. This holds across more than L consecutive steps.
- R8: If history age 0 was loaded while idle since the last output, the step skips the solution wait. sol_ready stays low, and rhs_valid rises N·N·(ceil(L/4)+1) cycles after the start edge.
- R9: While rhs_valid is high and rhs_ready is low, rhs_valid and rhs_data hold. After the last element is taken, the block returns to idle, and the next step needs a new solution.
- R10: During reset, rhs_valid and sol_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 coefficient, 1 history, 2 self-field |
| ld_term | input | $clog2(L) | Term index minus one, or history age |
| ld_row | input | $clog2(N) | Coefficient row |
| ld_col | input | $clog2(N) | Coefficient column or vector element |
| ld_data | input | 32 | Load word |
| start | input | 1 | Begin one step |
| sol_valid | input | 1 | Solution element present |
| sol_data | input | 32 | Solution element |
| sol_ready | output | 1 | Block accepts solution elements |
| rhs_valid | output | 1 | Output element present |
| rhs_data | output | 32 | Output element |
| rhs_ready | input | 1 | Solver takes output element |

## Verification
The bench first covers a step that starts with the newest history already loaded. A block that always waited for a solution would hang there, and one that skipped the G1 term would produce wrong sums. It measures the cycle at which sol_ready and rhs_valid rise, which catches a block that holds back all terms until the solution arrives, or that counts the term loop wrongly. It writes loads into a running step and runs more than L steps through the ring; a block that misaddressed the ring, or that let busy loads through, would show wrong elements. It also drives sums far beyond 32 bits in both directions, so a wrap in place of saturation would show. Output backpressure exposes data that does not hold while stalled.

// File: rtl/crhs_pkg.sv
package crhs_pkg;
  typedef enum logic [2:0] {
    CRHS_IDLE,
    CRHS_PRE,
    CRHS_WAIT,
    CRHS_FIN,
    CRHS_OUT
  } crhs_state_e;

  localparam logic [1:0] LDS_COEF = 2'd0;
  localparam logic [1:0] LDS_HIST = 2'd1;
  localparam logic [1:0] LDS_SELF = 2'd2;
endpackage

// File: rtl/crhs_seq.sv
module crhs_seq #(
  parameter int N     = 5,
  parameter int L     = 8,
  parameter int LANES = 4,
  parameter int TCW   = 1,
  parameter int IW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     newest,
  input  logic                     sol_valid,
  input  logic                     rhs_ready,
  output crhs_pkg::crhs_state_e    st_o,
  output logic [TCW-1:0]           t_o,
  output logic [IW-1:0]            row_o,
  output logic [IW-1:0]            col_o,
  output logic [IW-1:0]            beat_o,
  output logic                     clr_o,
  output logic                     mac_en_o,
  output logic                     fin_o,
  output logic                     sol_ready_o,
  output logic                     sol_take_o,
  output logic                     sol_last_o,
  output logic                     rhs_valid_o,
  output logic                     out_done_o
);
  import crhs_pkg::*;

  localparam int T = (L + LANES - 1) / LANES;

  crhs_state_e    st_q, st_d;
  logic [TCW-1:0] t_q, t_d;
  logic [IW-1:0]  row_q, row_d, col_q, col_d, beat_q, beat_d;
  logic           col_end, row_end, t_end, beat_end;

  assign col_end  = (col_q == IW'(N - 1));
  assign row_end  = (row_q == IW'(N - 1));
  assign t_end    = (t_q == TCW'(T - 1));
  assign beat_end = (beat_q == IW'(N - 1));

  always_comb begin
    st_d        = st_q;
    t_d         = t_q;
    row_d       = row_q;
    col_d       = col_q;
    beat_d      = beat_q;
    clr_o       = 1'b0;
    mac_en_o    = 1'b0;
    fin_o       = 1'b0;
    sol_ready_o = 1'b0;
    sol_last_o  = 1'b0;
    rhs_valid_o = 1'b0;
    out_done_o  = 1'b0;
    unique case (st_q)
      CRHS_IDLE: begin
        if (start) begin
          st_d   = CRHS_PRE;
          clr_o  = 1'b1;
          t_d    = '0;
          row_d  = '0;
          col_d  = '0;
          beat_d = '0;
        end
      end
      CRHS_PRE: begin
        mac_en_o = 1'b1;
        if (col_end) begin
          col_d = '0;
          if (row_end) begin
            row_d = '0;
            if (t_end) begin
              t_d  = '0;
              st_d = newest ? CRHS_FIN : CRHS_WAIT;
            end else begin
              t_d = t_q + 1'b1;
            end
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      CRHS_WAIT: begin
        sol_ready_o = 1'b1;
        if (sol_valid) begin
          if (beat_end) begin
            beat_d     = '0;
            sol_last_o = 1'b1;
            st_d       = CRHS_FIN;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      CRHS_FIN: begin
        mac_en_o = 1'b1;
        fin_o    = 1'b1;
        if (col_end) begin
          col_d = '0;
          if (row_end) begin
            row_d = '0;
            st_d  = CRHS_OUT;
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      CRHS_OUT: begin
        rhs_valid_o = 1'b1;
        if (rhs_ready) begin
          if (beat_end) begin
            beat_d     = '0;
            out_done_o = 1'b1;
            st_d       = CRHS_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: st_d = CRHS_IDLE;
    endcase
  end

  assign sol_take_o = sol_ready_o & sol_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CRHS_IDLE;
      t_q    <= '0;
      row_q  <= '0;
      col_q  <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      t_q    <= t_d;
      row_q  <= row_d;
      col_q  <= col_d;
      beat_q <= beat_d;
    end
  end

  assign st_o   = st_q;
  assign t_o    = t_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/crhs_coef_bank.sv
module crhs_coef_bank #(
  parameter int N     = 5,
  parameter int L     = 8,
  parameter int LANES = 4,
  parameter int LANE  = 0,
  parameter int DW    = 32,
  parameter int TCW   = 1,
  parameter int TW    = 3,
  parameter int IW    = 3
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [TW-1:0]        wr_term,
  input  logic [IW-1:0]        wr_row,
  input  logic [IW-1:0]        wr_col,
  input  logic signed [DW-1:0] wr_data,
  input  logic [TCW-1:0]       rd_t,
  input  logic [IW-1:0]        rd_row,
  input  logic [IW-1:0]        rd_col,
  output logic signed [DW-1:0] rd_data
);
  localparam int T = (L + LANES - 1) / LANES;

  logic signed [DW-1:0] mem [T][N][N];
  logic                 mine;
  logic [TCW-1:0]       wr_t;

  assign mine = we && (int'(wr_term) < L) && ((int'(wr_term) % LANES) == LANE);
  assign wr_t = TCW'(int'(wr_term) / LANES);

  always_ff @(posedge clk) begin
    if (mine) mem[wr_t][wr_row][wr_col] <= wr_data;
  end

  assign rd_data = mem[rd_t][rd_row][rd_col];
endmodule

// File: rtl/crhs_hist_ring.sv
module crhs_hist_ring #(
  parameter int N     = 5,
  parameter int L     = 8,
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int TW    = 3,
  parameter int IW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_we,
  input  logic [TW-1:0]        ld_age,
  input  logic [IW-1:0]        ld_elem,
  input  logic signed [DW-1:0] ld_data,
  input  logic                 sh_we,
  input  logic [IW-1:0]        sh_elem,
  input  logic signed [DW-1:0] sh_data,
  input  logic                 sh_commit,
  input  logic                 out_done,
  input  logic [TW-1:0]        rd_age  [LANES],
  input  logic [IW-1:0]        rd_elem,
  output logic signed [DW-1:0] rd_data [LANES],
  output logic                 newest_o
);
  logic signed [DW-1:0] mem [L][N];
  logic [TW-1:0]        head_q, head_d, head_nx;
  logic                 newest_q, newest_d;

  function automatic logic [TW-1:0] slot_of(input logic [TW-1:0] hd, input logic [TW-1:0] age);
    slot_of = TW'((int'(hd) + L - int'(age)) % L);
  endfunction

  assign head_nx = (head_q == TW'(L - 1)) ? '0 : head_q + 1'b1;

  always_comb begin
    head_d   = sh_commit ? head_nx : head_q;
    newest_d = newest_q;
    if (out_done) newest_d = 1'b0;
    if (ld_we && ld_age == '0) newest_d = 1'b1;
    if (sh_commit) newest_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      newest_q <= 1'b0;
    end else begin
      head_q   <= head_d;
      newest_q <= newest_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we) mem[slot_of(head_q, ld_age)][ld_elem] <= ld_data;
    else if (sh_we) mem[head_nx][sh_elem] <= sh_data;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_data[k] = mem[slot_of(head_q, rd_age[k])][rd_elem];
  end

  assign newest_o = newest_q;

  a_r7_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) |->
      (head_q == (($past(head_q) == TW'(L - 1)) ? TW'(0) : $past(head_q) + 1'b1)));

  a_r3_no_write_collide: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we && sh_we));
endmodule

// File: rtl/crhs_mac_lane.sv
module crhs_mac_lane #(
  parameter int N     = 5,
  parameter int L     = 8,
  parameter int LANES = 4,
  parameter int LANE  = 0,
  parameter int DW    = 32,
  parameter int AW    = 64,
  parameter int TCW   = 1,
  parameter int TW    = 3,
  parameter int IW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 mac_en,
  input  logic                 fin,
  input  logic                 newest,
  input  logic [TCW-1:0]       t_idx,
  input  logic [IW-1:0]        row,
  input  logic signed [DW-1:0] coef,
  input  logic signed [DW-1:0] hist,
  output logic [TW-1:0]        rd_age,
  output logic signed [AW-1:0] acc_o [N]
);
  localparam int PW = 2 * DW;

  int                   m;
  logic                 active;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q [N];
  logic signed [AW-1:0] acc_d [N];

  assign m      = int'(t_idx) * LANES + LANE;
  assign active = mac_en && (m < L) && (fin ? (m == 0) : (m != 0));
  assign rd_age = newest ? TW'(m) : TW'(m - 1);
  assign prod   = coef * hist;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      acc_d[i] = acc_q[i];
      if (clr) acc_d[i] = '0;
      else if (active && row == IW'(i)) acc_d[i] = acc_q[i] + AW'(prod);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) acc_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) acc_q[i] <= acc_d[i];
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/conv_rhs_engine.sv
module conv_rhs_engine #(
  parameter int N     = 5,
  parameter int L     = 8,
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int AW    = 64,
  localparam int TW   = (L > 1) ? $clog2(L) : 1,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [TW-1:0] ld_term,
  input  logic [IW-1:0] ld_row,
  input  logic [IW-1:0] ld_col,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic          sol_valid,
  input  logic [DW-1:0] sol_data,
  output logic          sol_ready,
  output logic          rhs_valid,
  output logic [DW-1:0] rhs_data,
  input  logic          rhs_ready
);
  import crhs_pkg::*;

  localparam int T   = (L + LANES - 1) / LANES;
  localparam int TCW = (T > 1) ? $clog2(T) : 1;
  localparam int SW  = AW + $clog2(LANES + 1) + 1;
  localparam logic signed [SW-1:0] SMAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [1:0]           rs_q;
  logic                 rst_s;
  crhs_state_e          st;
  logic [TCW-1:0]       t_cnt;
  logic [IW-1:0]        row, col, beat;
  logic                 clr, mac_en, fin, sol_take, sol_last, out_done, newest;
  logic                 ld_ok, self_we;
  logic signed [DW-1:0] bself_q [N];
  logic signed [DW-1:0] lane_coef [LANES];
  logic signed [DW-1:0] lane_hist [LANES];
  logic [TW-1:0]        lane_age  [LANES];
  logic signed [AW-1:0] lane_acc  [LANES][N];
  logic signed [SW-1:0] total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign ld_ok   = ld_en && (st == CRHS_IDLE);
  assign self_we = ld_ok && (ld_sel == LDS_SELF);

  crhs_seq #(.N(N), .L(L), .LANES(LANES), .TCW(TCW), .IW(IW)) seq_i (
    .clk(clk), .rst_n(rst_s), .start(start), .newest(newest),
    .sol_valid(sol_valid), .rhs_ready(rhs_ready), .st_o(st), .t_o(t_cnt),
    .row_o(row), .col_o(col), .beat_o(beat), .clr_o(clr), .mac_en_o(mac_en),
    .fin_o(fin), .sol_ready_o(sol_ready), .sol_take_o(sol_take),
    .sol_last_o(sol_last), .rhs_valid_o(rhs_valid), .out_done_o(out_done)
  );

  crhs_hist_ring #(.N(N), .L(L), .LANES(LANES), .DW(DW), .TW(TW), .IW(IW)) ring_i (
    .clk(clk), .rst_n(rst_s),
    .ld_we(ld_ok && (ld_sel == LDS_HIST)), .ld_age(ld_term), .ld_elem(ld_col),
    .ld_data(ld_data), .sh_we(sol_take), .sh_elem(beat), .sh_data(sol_data),
    .sh_commit(sol_last), .out_done(out_done), .rd_age(lane_age),
    .rd_elem(col), .rd_data(lane_hist), .newest_o(newest)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crhs_coef_bank #(.N(N), .L(L), .LANES(LANES), .LANE(k), .DW(DW),
                     .TCW(TCW), .TW(TW), .IW(IW)) bank_i (
      .clk(clk), .we(ld_ok && (ld_sel == LDS_COEF)), .wr_term(ld_term),
      .wr_row(ld_row), .wr_col(ld_col), .wr_data(ld_data),
      .rd_t(t_cnt), .rd_row(row), .rd_col(col), .rd_data(lane_coef[k])
    );
    crhs_mac_lane #(.N(N), .L(L), .LANES(LANES), .LANE(k), .DW(DW), .AW(AW),
                    .TCW(TCW), .TW(TW), .IW(IW)) mac_i (
      .clk(clk), .rst_n(rst_s), .clr(clr), .mac_en(mac_en), .fin(fin),
      .newest(newest), .t_idx(t_cnt), .row(row), .coef(lane_coef[k]),
      .hist(lane_hist[k]), .rd_age(lane_age[k]), .acc_o(lane_acc[k])
    );
  end

  always_ff @(posedge clk) begin
    if (self_we) bself_q[ld_col] <= ld_data;
  end

  always_comb begin
    total = SW'(bself_q[beat]);
    for (int k = 0; k < LANES; k++) total = total - SW'(lane_acc[k][beat]);
    if (total > SMAX)      rhs_data = SMAX[DW-1:0];
    else if (total < SMIN) rhs_data = SMIN[DW-1:0];
    else                   rhs_data = total[DW-1:0];
  end

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_s)
    (rhs_valid && !rhs_ready) |=> (rhs_valid && $stable(rhs_data)));

  a_r6_fin_has_newest: assert property (@(posedge clk) disable iff (!rst_s)
    (st == CRHS_FIN) |-> newest);

  a_r8_wait_only_stale: assert property (@(posedge clk) disable iff (!rst_s)
    sol_ready |-> !newest);

  a_r5_no_output_in_wait: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(sol_ready) |-> !rhs_valid && $past(mac_en));
endmodule

// File: tb/conv_rhs_engine_tb_top.sv
module conv_rhs_engine_tb_top;
  localparam int N = 5, L = 8, TW = 3, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 0, start = 0, sol_valid = 0, rhs_ready = 0;
  logic [1:0] ld_sel = 0;
  logic [TW-1:0] ld_term = 0;
  logic [IW-1:0] ld_row = 0, ld_col = 0;
  logic [31:0] ld_data = 0, sol_data = 0;
  logic sol_ready, rhs_valid;
  logic [31:0] rhs_data;

  int checks = 0, fails = 0;
  bit done = 0;
  longint mg [L][N][N];
  longint mh [L][N];
  longint mb [N];
  longint sv [N];
  longint got [N];

  conv_rhs_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_term(ld_term),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
    .sol_valid(sol_valid), .sol_data(sol_data), .sol_ready(sol_ready),
    .rhs_valid(rhs_valid), .rhs_data(rhs_data), .rhs_ready(rhs_ready)
  );

  always #10 clk = ~clk;

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic ld(logic [1:0] s, int term, int r, int c, longint v);
    ld_en = 1; ld_sel = s; ld_term = TW'(term); ld_row = IW'(r); ld_col = IW'(c);
    ld_data = 32'(v);
    cyc();
    ld_en = 0;
  endtask

  task automatic ld_coef(int m, int r, int c, longint v, bit upd);
    ld(2'd0, m, r, c, v); if (upd) mg[m][r][c] = v;
  endtask
  task automatic ld_hist(int a, int e, longint v);
    ld(2'd1, a, 0, e, v); mh[a][e] = v;
  endtask
  task automatic ld_self(int e, longint v, bit upd);
    ld(2'd2, 0, 0, e, v); if (upd) mb[e] = v;
  endtask

  task automatic do_start(); start = 1; cyc(); start = 0; endtask

  task automatic send_sol(bit gaps);
    for (int e = 0; e < N; e++) begin
      sol_valid = 1; sol_data = 32'(sv[e]);
      while (!sol_ready) cyc();
      cyc();
      sol_valid = 0;
      if (gaps && e != N - 1) cyc();
    end
    for (int a = L - 1; a > 0; a--) for (int e = 0; e < N; e++) mh[a][e] = mh[a-1][e];
    for (int e = 0; e < N; e++) mh[0][e] = sv[e];
  endtask

  task automatic collect(bit stall);
    logic [31:0] held;
    rhs_ready = 0;
    while (!rhs_valid) cyc();
    if (stall) begin
      held = rhs_data;
      repeat (3) cyc();
      check("R9 hold under backpressure", {31'd0, rhs_valid} + ((rhs_data == held) ? 0 : 2), 1);
    end
    rhs_ready = 1;
    for (int e = 0; e < N; e++) begin
      while (!rhs_valid) cyc();
      got[e] = longint'($signed(rhs_data));
      cyc();
    end
    rhs_ready = 0;
    check("R9 idle after last element", rhs_valid, 0);
  endtask

  task automatic compare(string req);
    for (int i = 0; i < N; i++) begin
      longint s = mb[i];
      for (int m = 0; m < L; m++) for (int j = 0; j < N; j++) s -= mg[m][i][j] * mh[m][j];
      check(req, got[i], sat(s));
    end
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    check("R10 rhs_valid in reset", rhs_valid, 0);
    check("R10 sol_ready in reset", sol_ready, 0);
    rst_n = 1;
    repeat (4) cyc();
  endtask

  task automatic t_first_step();
    int cnt = 0; bit seen = 0;
    for (int m = 0; m < L; m++) for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
      ld_coef(m, r, c, ((m * 7 + r * 3 + c * 5) % 11) - 5, 1);
    for (int a = 0; a < L; a++) for (int e = 0; e < N; e++) ld_hist(a, e, ((a * 5 + e * 3) % 13) - 6);
    for (int e = 0; e < N; e++) ld_self(e, e * 100 - 37, 1);
    do_start();
    while (!rhs_valid && cnt < 500) begin if (sol_ready) seen = 1; cyc(); cnt++; end
    check("R8 no solution wait", seen, 0);
    check("R8 latency start to output", cnt, 75);
    collect(0);
    compare("R1 first step");
  endtask

  task automatic t_overlap_step();
    int cnt = 0; bit ok = 1;
    for (int e = 0; e < N; e++) ld_self(e, 1000 - e * 211, 1);
    do_start();
    while (!sol_ready && cnt < 500) begin cyc(); cnt++; end
    check("R4 sol_ready after early terms", cnt, 50);
    for (int k = 0; k < 20; k++) begin
      if (rhs_valid || !sol_ready) ok = 0;
      cyc();
    end
    check("R5 stall while solver busy", ok, 1);
    ld_self(0, 999999, 0);
    ld_coef(0, 0, 0, 77, 0);
    for (int e = 0; e < N; e++) sv[e] = e * 9 - 17;
    send_sol(1);
    cnt = 0;
    while (!rhs_valid && cnt < 500) begin cyc(); cnt++; end
    check("R6 latency after last solution", cnt, 25);
    collect(1);
    compare("R3 busy loads ignored, R1 sums");
  endtask

  task automatic t_ring_steps();
    for (int s = 0; s < 10; s++) begin
      for (int e = 0; e < N; e++) ld_self(e, s * 50 - e * 7, 1);
      do_start();
      for (int e = 0; e < N; e++) sv[e] = ((s * 13 + e * 5) % 17) - 8;
      send_sol(s[0]);
      collect(0);
      compare("R7 history ring");
    end
  endtask

  task automatic t_saturate();
    bit seen = 0;
    for (int m = 0; m < L; m++) for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
      ld_coef(m, r, c, 0, 1);
    ld_coef(0, 0, 0, 100000, 1);
    ld_coef(0, 1, 0, -100000, 1);
    ld_hist(0, 0, 100000);
    for (int e = 0; e < N; e++) ld_self(e, 3, 1);
    do_start();
    while (!rhs_valid) begin if (sol_ready) seen = 1; cyc(); end
    check("R8 preloaded newest skips wait", seen, 0);
    collect(0);
    compare("R2 saturation");
    check("R2 low clamp", got[0], -64'sd2147483648);
    check("R2 high clamp", got[1], 64'sd2147483647);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_step();
    t_overlap_step();
    t_ring_steps();
    t_saturate();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule